// File: doc/BRIEF.md
# Condition Gate and Arithmetic Flag Register

This block decides whether an instruction may take effect and keeps the arithmetic flags that the decision is based on. A 4-bit condition code arrives with each instruction. The block tests that code against the stored negative, zero, carry and overflow flags. It raises an execute-enable in the same cycle, without a clock edge in between.

The block also holds a sticky saturation flag. When an ALU operation that is qualified to set flags finishes, the block takes the new flag values from the operation's 32-bit result and from its carry, overflow and saturation side signals. A separate write path lets a status-register write load all five flags directly. Both update paths obey the condition gate: an instruction whose condition fails leaves the flags untouched.

The flags appear in a 32-bit status word at the fixed positions N 31, Z 30, C 29, V 28 and Q 27. All other bits of the status word are zero.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is asserted (rst_n low), and after reset until the first update, status_o is all zeros.
- R2: An update sets N to bit 31 of res_i, and sets Z to 1 exactly when res_i is zero. The new value is visible on status_o after the rising edge that samples upd_i.
- R3: An update sets C to carry_i and V to ovf_i.
- R4: An update sets Q to 1 when sat_i or ovf_i is 1. An update never clears Q; only a direct write can clear it.
- R5: When upd_i and wr_i are both low, status_o keeps its value across clock edges.
- R6: exec_o follows these condition codes:
  - 0000: Z=1.
  - 0001: Z=0.
  - 0010: C=1.
  - 0011: C=0.
  - 0100: N=1.
  - 0101: N=0.
  - 0110: V=1.
  - 0111: V=0.
- R7: exec_o for the unsigned comparisons:
  - 1000: C=1 and Z=0.
  - 1001: C=0 or Z=1.
- R8: exec_o for the signed comparisons:
  - 1010: N==V.
  - 1011: N!=V.
  - 1100: Z=0 and N==V.
  - 1101: Z=1 or N!=V.
- R9: Code 1110 always gives exec_o=1, and code 1111 always gives exec_o=0.
- R10: When exec_o is 0, neither upd_i nor wr_i changes status_o.
- R11: A write (wr_i with exec_o high) loads wr_flags_i, ordered {N,Z,C,V,Q} from bit 4 down to bit 0, into status_o[31:27]. A write can clear Q. A write takes priority over an update in the same cycle. status_o[26:0] stays zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_i | input | 4 | Condition code of the current instruction |
| exec_o | output | 1 | Execute-enable for the current instruction |
| upd_i | input | 1 | ALU operation with the set-flags qualifier completes |
| res_i | input | 32 | ALU result |
| carry_i | input | 1 | Unsigned carry out of the ALU |
| ovf_i | input | 1 | Signed overflow from the ALU |
| sat_i | input | 1 | Saturation from the ALU |
| wr_i | input | 1 | Direct flag write |
| wr_flags_i | input | 5 | Flag values to write, {N,Z,C,V,Q} |
| status_o | output | 32 | Status word with the flags at bits 31..27 |

## Verification
exec_o is combinational from cond_i and the registered flags. It is therefore due in the same cycle as the condition code, and the bench samples it 1 ns after driving cond_i on the falling edge. Any update or write is registered once, so its effect on status_o is due after the next rising edge. The bench drives these inputs on a falling edge, lets one rising edge pass, and reads status_o at the following falling edge. Each condition vector first loads the flags through an always-true write and only then applies the code under test, so the two timings never overlap.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

    localparam int unsigned STATUS_W = 32;
    localparam int unsigned FLAG_CNT = 5;
    localparam int unsigned FLAG_TOP = 31;
    localparam int unsigned FLAG_LSB = FLAG_TOP - FLAG_CNT + 1;

    typedef enum logic [3:0] {
        CC_EQ = 4'h0,
        CC_NE = 4'h1,
        CC_CS = 4'h2,
        CC_CC = 4'h3,
        CC_MI = 4'h4,
        CC_PL = 4'h5,
        CC_VS = 4'h6,
        CC_VC = 4'h7,
        CC_HI = 4'h8,
        CC_LS = 4'h9,
        CC_GE = 4'hA,
        CC_LT = 4'hB,
        CC_GT = 4'hC,
        CC_LE = 4'hD,
        CC_AL = 4'hE,
        CC_NV = 4'hF
    } cond_e;

    // Packed with n as the top bit so the struct maps onto status bits 31..27.
    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
        logic q;
    } flags_t;

endpackage

// File: rtl/cfu_cond_eval.sv
module cfu_cond_eval
    import cfu_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       take_o
);

    cond_e  code;
    logic   sgn_eq;

    assign code   = cond_e'(cond_i);
    assign sgn_eq = (flags_i.n == flags_i.v);

    always_comb begin
        unique case (code)
            CC_EQ: take_o = flags_i.z;
            CC_NE: take_o = !flags_i.z;
            CC_CS: take_o = flags_i.c;
            CC_CC: take_o = !flags_i.c;
            CC_MI: take_o = flags_i.n;
            CC_PL: take_o = !flags_i.n;
            CC_VS: take_o = flags_i.v;
            CC_VC: take_o = !flags_i.v;
            CC_HI: take_o = flags_i.c && !flags_i.z;
            CC_LS: take_o = !flags_i.c || flags_i.z;
            CC_GE: take_o = sgn_eq;
            CC_LT: take_o = !sgn_eq;
            CC_GT: take_o = !flags_i.z && sgn_eq;
            CC_LE: take_o = flags_i.z || !sgn_eq;
            CC_AL: take_o = 1'b1;
            CC_NV: take_o = 1'b0;
            default: take_o = 1'b0;
        endcase
    end

    // R9: the two fixed codes ignore the flags.
    always_comb begin
        if (cond_i == 4'hE) begin
            p_always_r9: assert (take_o);
        end
        if (cond_i == 4'hF) begin
            p_never_r9: assert (!take_o);
        end
    end

    // R8: a signed-greater result excludes signed-less for the same flags.
    always_comb begin
        if (cond_i == 4'hC && take_o) begin
            p_gt_not_lt_r8: assert (sgn_eq);
        end
    end

endmodule

// File: rtl/cfu_flag_calc.sv
module cfu_flag_calc
    import cfu_pkg::*;
#(
    parameter int unsigned RES_W = 32
) (
    input  logic [RES_W-1:0] res_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    input  logic             sat_i,
    input  logic             cur_q_i,
    output flags_t           nxt_o
);

    always_comb begin
        nxt_o.n = res_i[RES_W-1];
        nxt_o.z = (res_i == '0);
        nxt_o.c = carry_i;
        nxt_o.v = ovf_i;
        nxt_o.q = cur_q_i | sat_i | ovf_i;
    end

endmodule

// File: rtl/cfu_flag_reg.sv
module cfu_flag_reg
    import cfu_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   upd_en_i,
    input  logic   wr_en_i,
    input  flags_t upd_flags_i,
    input  flags_t wr_flags_i,
    output flags_t flags_o
);

    flags_t flags_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else if (wr_en_i) begin
            flags_q <= wr_flags_i;
        end else if (upd_en_i) begin
            flags_q <= upd_flags_i;
        end
    end

    assign flags_o = flags_q;

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_en_i && !wr_en_i) |=> $stable(flags_q));

    p_q_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.q && !wr_en_i) |=> flags_q.q);

    p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (flags_q == $past(wr_flags_i)));

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
    import cfu_pkg::*;
#(
    parameter int unsigned RES_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          cond_i,
    output logic                exec_o,
    input  logic                upd_i,
    input  logic [RES_W-1:0]    res_i,
    input  logic                carry_i,
    input  logic                ovf_i,
    input  logic                sat_i,
    input  logic                wr_i,
    input  logic [FLAG_CNT-1:0] wr_flags_i,
    output logic [STATUS_W-1:0] status_o
);

    flags_t flags;
    flags_t upd_flags;
    logic   take;

    cfu_cond_eval u_eval (
        .cond_i  (cond_i),
        .flags_i (flags),
        .take_o  (take)
    );

    cfu_flag_calc #(.RES_W(RES_W)) u_calc (
        .res_i   (res_i),
        .carry_i (carry_i),
        .ovf_i   (ovf_i),
        .sat_i   (sat_i),
        .cur_q_i (flags.q),
        .nxt_o   (upd_flags)
    );

    cfu_flag_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en_i    (upd_i && take),
        .wr_en_i     (wr_i && take),
        .upd_flags_i (upd_flags),
        .wr_flags_i  (flags_t'(wr_flags_i)),
        .flags_o     (flags)
    );

    assign exec_o = take;

    always_comb begin
        status_o = '0;
        status_o[FLAG_TOP -: FLAG_CNT] = flags;
    end

    p_fail_no_effect_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_o |=> $stable(status_o));

    p_n_from_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && exec_o && !wr_i) |=> (status_o[FLAG_TOP] == $past(res_i[RES_W-1])));

    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && exec_o && !wr_i) |=> (status_o[FLAG_TOP-2] == $past(carry_i)));

    p_low_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (status_o[FLAG_LSB-1:0] == '0));

endmodule

// File: tb/test_cond_flag_unit.sv
module test_cond_flag_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cond = 4'hE;
    logic        exec;
    logic        upd = 1'b0;
    logic [31:0] res = '0;
    logic        carry = 1'b0;
    logic        ovf = 1'b0;
    logic        sat = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  wflags = '0;
    logic [31:0] status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .cond_i     (cond),
        .exec_o     (exec),
        .upd_i      (upd),
        .res_i      (res),
        .carry_i    (carry),
        .ovf_i      (ovf),
        .sat_i      (sat),
        .wr_i       (wr),
        .wr_flags_i (wflags),
        .status_o   (status)
    );

    // Each vector packs {cond[3:0], nzcv[3:0], expected exec}.
    localparam logic [8:0] VEC [26] = '{
        {4'h0, 4'b0100, 1'b1}, {4'h0, 4'b0000, 1'b0},
        {4'h1, 4'b0000, 1'b1}, {4'h1, 4'b0100, 1'b0},
        {4'h2, 4'b0010, 1'b1}, {4'h3, 4'b0010, 1'b0},
        {4'h4, 4'b1000, 1'b1}, {4'h5, 4'b1000, 1'b0},
        {4'h6, 4'b0001, 1'b1}, {4'h7, 4'b0001, 1'b0},
        {4'h8, 4'b0010, 1'b1}, {4'h8, 4'b0110, 1'b0},
        {4'h9, 4'b0000, 1'b1}, {4'h9, 4'b0010, 1'b0},
        {4'hA, 4'b1001, 1'b1}, {4'hA, 4'b1000, 1'b0},
        {4'hB, 4'b1000, 1'b1}, {4'hB, 4'b0000, 1'b0},
        {4'hC, 4'b0000, 1'b1}, {4'hC, 4'b0100, 1'b0},
        {4'hC, 4'b1000, 1'b0}, {4'hD, 4'b0100, 1'b1},
        {4'hD, 4'b0001, 1'b1}, {4'hD, 4'b0000, 1'b0},
        {4'hE, 4'b0000, 1'b1}, {4'hF, 4'b1111, 1'b0}
    };

    function automatic string req_of(input logic [3:0] c);
        if (c < 4'h8) return "R6";
        if (c < 4'hA) return "R7";
        if (c < 4'hE) return "R8";
        return "R9";
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge sample, return at the next falling edge.
    task automatic step(input logic [3:0] c, input logic u, input logic [31:0] r,
                        input logic ca, input logic o, input logic s,
                        input logic w, input logic [4:0] wf);
        cond = c; upd = u; res = r; carry = ca; ovf = o; sat = s; wr = w; wflags = wf;
        @(posedge clk);
        @(negedge clk);
        upd = 1'b0; wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", status, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", status, 32'h0);

        foreach (VEC[i]) begin
            step(4'hE, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, {VEC[i][4:1], 1'b0});
            cond = VEC[i][8:5];
            #1;
            check(req_of(VEC[i][8:5]), {31'h0, exec}, {31'h0, VEC[i][0]});
        end

        // Clear flags, then an update with N and C from the result side signals.
        step(4'hE, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00000);
        step(4'hE, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, '0);
        check("R2 R3", status, 32'hA000_0000);
        // Zero result with overflow: Z, V and Q set.
        step(4'hE, 1'b1, 32'h0, 1'b0, 1'b1, 1'b0, 1'b0, '0);
        check("R2 R3 R4", status, 32'h5800_0000);
        // Plain update keeps the sticky Q.
        step(4'hE, 1'b1, 32'h5, 1'b0, 1'b0, 1'b0, 1'b0, '0);
        check("R4", status, 32'h0800_0000);
        // Direct write clears Q, then saturation alone sets it.
        step(4'hE, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b00000);
        check("R11", status, 32'h0);
        step(4'hE, 1'b1, 32'h1, 1'b0, 1'b0, 1'b1, 1'b0, '0);
        check("R4", status, 32'h0800_0000);
        // No strobe: flags hold despite busy data inputs.
        step(4'hE, 1'b0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 5'b11111);
        check("R5", status, 32'h0800_0000);
        // Failing condition (EQ with Z=0) blocks update and write.
        step(4'h0, 1'b1, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, '0);
        check("R10", status, 32'h0800_0000);
        step(4'h0, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b11111);
        check("R10", status, 32'h0800_0000);
        step(4'hF, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 5'b11110);
        check("R10", status, 32'h0800_0000);
        // Write and update together: write wins.
        step(4'hE, 1'b1, 32'h8000_0000, 1'b1, 1'b0, 1'b0, 1'b1, 5'b01010);
        check("R11", status, 32'h5000_0000);
        // All-ones write leaves low status bits zero.
        step(4'hE, 1'b0, '0, 1'b0, 1'b0, 1'b0, 1'b1, 5'b11111);
        check("R11", status, 32'hF800_0000);
        // Reset clears everything again.
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1", status, 32'h0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule